// File: doc/BRIEF.md
# Reshapeable Dual-Clock FIFO Controller

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks. It holds one fixed storage array. A 3-bit shape code sets the word width, which is the same on both ports. The depth follows from the width: 1 bit by 4096, 2 by 2048, 4 by 1024, 9 by 512, 18 by 256 or 36 by 128. Narrow words are packed inside 9-bit storage lanes. Wide words take two or four lanes at once.

Each side runs its own binary pointer with one extra wrap bit. The pointer crosses to the other side in Gray code through a two-stage synchronizer. FULL and a programmable almost-full flag are computed in the write domain. EMPTY and a programmable almost-empty flag are computed in the read domain. Each 8-bit threshold is scaled to the chosen depth. A synchronous, active-high clear puts both sides back to empty. The shape code is meant to change only while clear is held. Each clock input has its own inversion select, which picks the edge that is active.

Top module: `aspect_fifo`

## Requirements
- R1: While `clr` is high, each domain is emptied on its own active edge. After that edge, `full` and `almost_full` are 0, `empty` and `almost_empty` are 1, and `rd_data` is 0.
- R2: A word is accepted on an active write edge when `wr_en` is 1 and `full` is 0. Words come out in write order. Each read edge with `rd_en` high and `empty` low loads the next word into `rd_data`. Only the low W bits carry data, and the bits above W read as zero.
- R3: `full` rises on the same write edge that makes the fill level equal to the depth. Writes attempted while `full` is high leave the stored contents unchanged.
- R4: A read attempted while `empty` is high has no effect, and `rd_data` keeps its last value.
- R5: After a write, `empty` falls on the second active read edge. After a read, `full` falls on the second active write edge. Each pointer crosses domains in Gray code, so at most one bit changes per update.
- R6: The shape code on `width_sel` gives word width W and depth D as follows: 0 → 1×4096, 1 → 2×2048, 2 → 4×1024, 3 → 9×512, 4 → 18×256, 5 → 36×128.
- R7: `almost_full` is 1 in the write domain when fill ≥ max(1, floor(`af_level`·D/256)). It updates on the write edge itself.
- R8: `almost_empty` is 1 in the read domain when fill ≤ floor(`ae_level`·D/256).
- R9: With `wr_clk_inv` and `rd_clk_inv` set to 1, the falling edges of `wr_clk` and `rd_clk` are the active ones. Rising edges then do nothing.
- R10: Shape codes 6 and 7 are reserved. Writes and reads are ignored under them, so `empty` stays 1 and `rd_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_clk_inv | input | 1 | 1 selects the falling write edge |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word, low W bits used |
| rd_clk | input | 1 | Read clock |
| rd_clk_inv | input | 1 | 1 selects the falling read edge |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Last word read, zero above W |
| clr | input | 1 | Synchronous clear, active high, in both domains |
| width_sel | input | 3 | Shape code |
| af_level | input | 8 | Almost-full threshold in 1/256 of depth |
| ae_level | input | 8 | Almost-empty threshold in 1/256 of depth |
| full | output | 1 | No room for another word |
| empty | output | 1 | No word available |
| almost_full | output | 1 | Fill at or above the scaled threshold |
| almost_empty | output | 1 | Fill at or below the scaled threshold |

## Verification
Results become visible at different edges, and the bench samples each one at the edge where it is due:

| Result | Due on |
|---|---|
| `full`, `almost_full` after a write | the same write edge |
| `empty`, `almost_empty` after a read | the same read edge |
| `rd_data` | the read edge that accepts the word |
| `empty` after a write | the second read edge |
| `full` after a read | the second write edge |

Every check is taken 5 ns after an active edge, and the bench counts edges from the stimulus before it compares. The two synchronizer lags are checked one edge at a time. The flag must still hold its old value after the first edge and must change after the second.

The polarity test opens a request window that contains only one kind of edge. A write therefore shows up only if the selected edge is the one that is active.

// File: rtl/aspect_fifo_pkg.sv
package aspect_fifo_pkg;

    localparam int DATA_W  = 36;
    localparam int LANE_W  = 9;
    localparam int LANES   = DATA_W / LANE_W;
    localparam int ENTRIES = 512;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int ADDR_W  = 12;
    localparam int PTR_W   = ADDR_W + 1;
    localparam int LVL_W   = 8;
    localparam int CODE_W  = 3;
    localparam int SHAPES  = 6;

    // One code per width/depth aspect; the code value is the right shift of
    // the largest depth.
    typedef enum logic [CODE_W-1:0] {
        SHAPE_W1  = 3'd0,
        SHAPE_W2  = 3'd1,
        SHAPE_W4  = 3'd2,
        SHAPE_W9  = 3'd3,
        SHAPE_W18 = 3'd4,
        SHAPE_W36 = 3'd5
    } shape_e;

    typedef logic [PTR_W-1:0] ptr_t;

    // A transfer request passed from a pointer controller to the storage.
    typedef struct packed {
        logic              fire;
        logic [ADDR_W-1:0] addr;
    } xfer_t;

    function automatic logic shape_ok(input logic [CODE_W-1:0] c);
        return c < CODE_W'(SHAPES);
    endfunction

    function automatic ptr_t shape_depth(input logic [CODE_W-1:0] c);
        if (shape_ok(c))
            return ptr_t'(1 << ADDR_W) >> c;
        return ptr_t'(1 << ADDR_W) >> (SHAPES - 1);
    endfunction

    // The level is given in 1/256 steps of the configured depth.
    function automatic ptr_t scale_level(input logic [CODE_W-1:0] c,
                                         input logic [LVL_W-1:0] lvl);
        logic [PTR_W+LVL_W-1:0] prod;
        prod = (PTR_W+LVL_W)'(lvl) * (PTR_W+LVL_W)'(shape_depth(c));
        return ptr_t'(prod >> LVL_W);
    endfunction

    function automatic ptr_t bin2gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(input ptr_t g);
        ptr_t b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--)
            b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

endpackage

// File: rtl/aspect_fifo_sync2.sv
module aspect_fifo_sync2 #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (clr) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/aspect_fifo_wr.sv
module aspect_fifo_wr
    import aspect_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic [CODE_W-1:0] shape,
    input  logic              wr_en,
    input  logic [LVL_W-1:0]  level,
    input  ptr_t              peer_gray,
    output ptr_t              own_gray,
    output xfer_t             req,
    output logic              full,
    output logic              almost_full
);

    ptr_t bin, bin_nxt, peer_sync, peer_bin, fill, depth, thr;

    aspect_fifo_sync2 #(.W(PTR_W)) u_sync (
        .clk (clk),
        .clr (clr),
        .d   (peer_gray),
        .q   (peer_sync)
    );

    always_comb begin
        depth    = shape_depth(shape);
        peer_bin = gray2bin(peer_sync);
        fill     = bin - peer_bin;
        full     = fill >= depth;
        thr      = scale_level(shape, level);
        if (thr == '0)
            thr = ptr_t'(1);
        almost_full = fill >= thr;
        req.fire = wr_en && !full && shape_ok(shape);
        req.addr = bin[ADDR_W-1:0] & (depth[ADDR_W-1:0] - ADDR_W'(1));
        bin_nxt  = bin + ptr_t'(1);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            bin      <= '0;
            own_gray <= '0;
        end else if (req.fire) begin
            bin      <= bin_nxt;
            own_gray <= bin2gray(bin_nxt);
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (clr)
        fill <= depth) else $error("write side fill beyond depth");

    assert_full_holds_ptr_R3: assert property (@(posedge clk) disable iff (clr)
        full |=> bin == $past(bin)) else $error("write pointer moved while full");

    assert_wr_clear_flags_R1: assert property (@(posedge clk) disable iff (clr)
        $past(clr) |-> (!full && !almost_full)) else $error("write flags after clear");

    assert_wr_gray_step_R5: assert property (@(posedge clk) disable iff (clr)
        !$past(clr) |-> $countones(own_gray ^ $past(own_gray)) <= 1)
        else $error("write Gray pointer moved by more than one bit");

endmodule

// File: rtl/aspect_fifo_rd.sv
module aspect_fifo_rd
    import aspect_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic [CODE_W-1:0] shape,
    input  logic              rd_en,
    input  logic [LVL_W-1:0]  level,
    input  ptr_t              peer_gray,
    output ptr_t              own_gray,
    output xfer_t             req,
    output logic              empty,
    output logic              almost_empty
);

    ptr_t bin, bin_nxt, peer_sync, peer_bin, fill, depth;

    aspect_fifo_sync2 #(.W(PTR_W)) u_sync (
        .clk (clk),
        .clr (clr),
        .d   (peer_gray),
        .q   (peer_sync)
    );

    always_comb begin
        depth        = shape_depth(shape);
        peer_bin     = gray2bin(peer_sync);
        fill         = peer_bin - bin;
        empty        = fill == '0;
        almost_empty = fill <= scale_level(shape, level);
        req.fire     = rd_en && !empty && shape_ok(shape);
        req.addr     = bin[ADDR_W-1:0] & (depth[ADDR_W-1:0] - ADDR_W'(1));
        bin_nxt      = bin + ptr_t'(1);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            bin      <= '0;
            own_gray <= '0;
        end else if (req.fire) begin
            bin      <= bin_nxt;
            own_gray <= bin2gray(bin_nxt);
        end
    end

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (clr)
        empty |=> $stable(bin)) else $error("read pointer moved while empty");

    assert_rd_fill_bound_R3: assert property (@(posedge clk) disable iff (clr)
        fill <= depth) else $error("read side fill beyond depth");

    assert_rd_clear_flags_R1: assert property (@(posedge clk) disable iff (clr)
        $past(clr) |-> (empty && almost_empty)) else $error("read flags after clear");

    assert_rd_gray_step_R5: assert property (@(posedge clk) disable iff (clr)
        !$past(clr) |-> $countones(own_gray ^ $past(own_gray)) <= 1)
        else $error("read Gray pointer moved by more than one bit");

endmodule

// File: rtl/aspect_fifo_store.sv
module aspect_fifo_store
    import aspect_fifo_pkg::*;
(
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              clr,
    input  logic [CODE_W-1:0] shape,
    input  xfer_t             wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  xfer_t             rd_req,
    output logic [DATA_W-1:0] rd_data
);

    localparam int HALF = LANES / 2;

    logic [LANE_W-1:0] mem [ENTRIES];
    logic [ADDR_W-1:0] wa, ra;
    logic [DATA_W-1:0] rd_word;

    assign wa = wr_req.addr;
    assign ra = rd_req.addr;

    // Narrow shapes pack into the low 8 bits of a lane; wide shapes span lanes.
    always_ff @(posedge wr_clk) begin
        if (wr_req.fire) begin
            case (shape_e'(shape))
                SHAPE_W1:  mem[IDX_W'(wa >> 3)][wa[2:0]] <= wr_data[0];
                SHAPE_W2:  mem[IDX_W'(wa >> 2)][{wa[1:0], 1'b0} +: 2] <= wr_data[1:0];
                SHAPE_W4:  mem[IDX_W'(wa >> 1)][{wa[0], 2'b00} +: 4] <= wr_data[3:0];
                SHAPE_W9:  mem[IDX_W'(wa)] <= wr_data[LANE_W-1:0];
                SHAPE_W18: begin
                    for (int k = 0; k < HALF; k++)
                        mem[IDX_W'({wa, 1'b0}) | IDX_W'(k)] <= wr_data[k*LANE_W +: LANE_W];
                end
                SHAPE_W36: begin
                    for (int k = 0; k < LANES; k++)
                        mem[IDX_W'({wa, 2'b00}) | IDX_W'(k)] <= wr_data[k*LANE_W +: LANE_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        case (shape_e'(shape))
            SHAPE_W1:  rd_word[0]   = mem[IDX_W'(ra >> 3)][ra[2:0]];
            SHAPE_W2:  rd_word[1:0] = mem[IDX_W'(ra >> 2)][{ra[1:0], 1'b0} +: 2];
            SHAPE_W4:  rd_word[3:0] = mem[IDX_W'(ra >> 1)][{ra[0], 2'b00} +: 4];
            SHAPE_W9:  rd_word[LANE_W-1:0] = mem[IDX_W'(ra)];
            SHAPE_W18: begin
                for (int k = 0; k < HALF; k++)
                    rd_word[k*LANE_W +: LANE_W] = mem[IDX_W'({ra, 1'b0}) | IDX_W'(k)];
            end
            SHAPE_W36: begin
                for (int k = 0; k < LANES; k++)
                    rd_word[k*LANE_W +: LANE_W] = mem[IDX_W'({ra, 2'b00}) | IDX_W'(k)];
            end
            default: ;
        endcase
    end

    always_ff @(posedge rd_clk) begin
        if (clr)
            rd_data <= '0;
        else if (rd_req.fire)
            rd_data <= rd_word;
    end

endmodule

// File: rtl/aspect_fifo.sv
module aspect_fifo
    import aspect_fifo_pkg::*;
(
    input  logic              wr_clk,
    input  logic              wr_clk_inv,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_clk_inv,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              clr,
    input  logic [CODE_W-1:0] width_sel,
    input  logic [LVL_W-1:0]  af_level,
    input  logic [LVL_W-1:0]  ae_level,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty
);

    logic  wclk, rclk;
    ptr_t  wr_gray, rd_gray;
    xfer_t wr_req, rd_req;

    assign wclk = wr_clk ^ wr_clk_inv;
    assign rclk = rd_clk ^ rd_clk_inv;

    aspect_fifo_wr u_wr (
        .clk         (wclk),
        .clr         (clr),
        .shape       (width_sel),
        .wr_en       (wr_en),
        .level       (af_level),
        .peer_gray   (rd_gray),
        .own_gray    (wr_gray),
        .req         (wr_req),
        .full        (full),
        .almost_full (almost_full)
    );

    aspect_fifo_rd u_rd (
        .clk          (rclk),
        .clr          (clr),
        .shape        (width_sel),
        .rd_en        (rd_en),
        .level        (ae_level),
        .peer_gray    (wr_gray),
        .own_gray     (rd_gray),
        .req          (rd_req),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    aspect_fifo_store u_store (
        .wr_clk  (wclk),
        .rd_clk  (rclk),
        .clr     (clr),
        .shape   (width_sel),
        .wr_req  (wr_req),
        .wr_data (wr_data),
        .rd_req  (rd_req),
        .rd_data (rd_data)
    );

endmodule

// File: tb/aspect_fifo_tb.sv
module aspect_fifo_tb;

    typedef struct packed {
        logic [2:0]  code;
        logic [35:0] din;
        logic [35:0] dout;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 36'hF_FFFF_FFFE, 36'h0_0000_0000},
        '{3'd0, 36'h0_0000_0001, 36'h0_0000_0001},
        '{3'd1, 36'h0_0000_0006, 36'h0_0000_0002},
        '{3'd2, 36'h0_0000_0ABC, 36'h0_0000_000C},
        '{3'd3, 36'h0_0000_75A5, 36'h0_0000_01A5},
        '{3'd4, 36'hF_0003_FFFF, 36'h0_0003_FFFF},
        '{3'd5, 36'hC_3A5A_5A5A, 36'hC_3A5A_5A5A}
    };

    logic        clk = 1'b0;
    logic        wr_clk_inv, rd_clk_inv, wr_en, rd_en, clr;
    logic [35:0] wr_data, rd_data;
    logic [2:0]  width_sel;
    logic [7:0]  af_level, ae_level;
    logic        full, empty, almost_full, almost_empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    aspect_fifo u_dut (
        .wr_clk       (clk),
        .wr_clk_inv   (wr_clk_inv),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_clk       (clk),
        .rd_clk_inv   (rd_clk_inv),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .clr          (clr),
        .width_sel    (width_sel),
        .af_level     (af_level),
        .ae_level     (ae_level),
        .full         (full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #5;
    endtask

    task automatic do_clear(input logic [2:0] code);
        clr = 1'b1; wr_en = 1'b0; rd_en = 1'b0; width_sel = code;
        repeat (3) cycle();
        clr = 1'b0;
    endtask

    function automatic int wid(input int c);
        case (c)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 9;
            4: return 18;
            5: return 36;
            default: return 0;
        endcase
    endfunction

    function automatic logic [35:0] msk(input int c);
        if (wid(c) == 36) return '1;
        return (36'h1 << wid(c)) - 36'h1;
    endfunction

    function automatic logic [35:0] pat(input int i);
        return 36'(i * 32'h9E37_79B1) ^ 36'(i >> 3) ^ {4'(i), 32'h0};
    endfunction

    task automatic write_n(input int n);
        for (int i = 0; i < n; i++) begin
            wr_data = pat(i); wr_en = 1'b1; cycle();
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [35:0] last;
        int n, m, bad;
        clr = 1'b1; wr_clk_inv = 1'b0; rd_clk_inv = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_data = '0; width_sel = 3'd5; af_level = 8'd128; ae_level = 8'd16;

        // R1: state after clear
        do_clear(3'd5);
        chk("R1 full", 36'(full), 36'h0);
        chk("R1 almost_full", 36'(almost_full), 36'h0);
        chk("R1 empty", 36'(empty), 36'h1);
        chk("R1 almost_empty", 36'(almost_empty), 36'h1);
        chk("R1 rd_data", rd_data, 36'h0);

        // R2: table of single-word transfers over every shape
        for (int v = 0; v < NV; v++) begin
            do_clear(VECS[v].code);
            wr_data = VECS[v].din; wr_en = 1'b1; cycle(); wr_en = 1'b0;
            repeat (2) cycle();
            rd_en = 1'b1; cycle(); rd_en = 1'b0;
            chk($sformatf("R2 vector %0d", v), rd_data, VECS[v].dout);
        end

        // R5: empty falls on the second read edge after a write
        do_clear(3'd5);
        wr_data = 36'h1_2345_6789; wr_en = 1'b1; cycle(); wr_en = 1'b0;
        chk("R5 empty at write edge", 36'(empty), 36'h1);
        cycle();
        chk("R5 empty one edge later", 36'(empty), 36'h1);
        cycle();
        chk("R5 empty two edges later", 36'(empty), 36'h0);

        // R6 / R3 / R2: fill each shape to full, try overflow, drain in order
        for (int c = 0; c < 6; c++) begin
            do_clear(3'(c));
            n = 0;
            wr_en = 1'b1;
            while (!full && n < 5000) begin
                wr_data = pat(n); cycle(); n++;
            end
            wr_data = ~pat(0); repeat (2) cycle();
            wr_en = 1'b0;
            chk($sformatf("R6 R3 depth code %0d", c), 36'(n), 36'(4096 >> c));
            repeat (3) cycle();
            m = 0; bad = 0;
            rd_en = 1'b1;
            while (!empty && m < 5000) begin
                cycle();
                if (rd_data !== (pat(m) & msk(c))) bad++;
                m++;
            end
            rd_en = 1'b0;
            chk($sformatf("R3 words out code %0d", c), 36'(m), 36'(4096 >> c));
            chk($sformatf("R2 R6 data code %0d", c), 36'(bad), 36'h0);
        end

        // R4: read on empty leaves rd_data alone
        last = rd_data;
        rd_en = 1'b1; cycle(); rd_en = 1'b0;
        chk("R4 rd_data held", rd_data, last);
        chk("R4 still empty", 36'(empty), 36'h1);

        // R5: full falls on the second write edge after a read
        do_clear(3'd5);
        write_n(128);
        chk("R3 full at depth", 36'(full), 36'h1);
        rd_en = 1'b1; cycle(); rd_en = 1'b0;
        chk("R5 full at read edge", 36'(full), 36'h1);
        cycle();
        chk("R5 full one edge later", 36'(full), 36'h1);
        cycle();
        chk("R5 full two edges later", 36'(full), 36'h0);

        // R7 / R8 on depth 128: thresholds 64 -> 32 and 16 -> 8
        do_clear(3'd5);
        af_level = 8'd64; ae_level = 8'd16;
        for (int i = 1; i <= 32; i++) begin
            wr_data = pat(i); wr_en = 1'b1; cycle(); wr_en = 1'b0;
            if (i == 31) chk("R7 almost_full below", 36'(almost_full), 36'h0);
            if (i == 32) chk("R7 almost_full at level", 36'(almost_full), 36'h1);
        end
        repeat (3) cycle();
        chk("R8 almost_empty above", 36'(almost_empty), 36'h0);
        rd_en = 1'b1; repeat (23) cycle(); rd_en = 1'b0;
        chk("R8 almost_empty fill 9", 36'(almost_empty), 36'h0);
        rd_en = 1'b1; cycle(); rd_en = 1'b0;
        chk("R8 almost_empty fill 8", 36'(almost_empty), 36'h1);

        // R7 / R8 scaling on depth 4096: level 1 -> 16
        do_clear(3'd0);
        af_level = 8'd1; ae_level = 8'd1;
        for (int i = 1; i <= 16; i++) begin
            wr_data = pat(i); wr_en = 1'b1; cycle(); wr_en = 1'b0;
            if (i == 15) chk("R7 scaled almost_full 15", 36'(almost_full), 36'h0);
            if (i == 16) chk("R7 scaled almost_full 16", 36'(almost_full), 36'h1);
        end
        repeat (3) cycle();
        chk("R8 scaled almost_empty 16", 36'(almost_empty), 36'h1);
        wr_en = 1'b1; cycle(); wr_en = 1'b0;
        repeat (3) cycle();
        chk("R8 scaled almost_empty 17", 36'(almost_empty), 36'h0);

        // R7: zero level behaves as one word
        do_clear(3'd5);
        af_level = 8'd0;
        chk("R7 zero level after clear", 36'(almost_full), 36'h0);
        wr_en = 1'b1; cycle(); wr_en = 1'b0;
        chk("R7 zero level one word", 36'(almost_full), 36'h1);

        // R9: falling edges active when inverted
        clr = 1'b1; wr_en = 1'b0; rd_en = 1'b0; width_sel = 3'd5; cycle();
        wr_clk_inv = 1'b1; rd_clk_inv = 1'b1;
        repeat (3) cycle();
        clr = 1'b0;
        wr_data = 36'h5_0F0F_1234; wr_en = 1'b1; #10; wr_en = 1'b0;
        cycle();
        chk("R9 empty after falling write", 36'(empty), 36'h1);
        cycle(); cycle();
        chk("R9 word landed on falling edge", 36'(empty), 36'h0);
        rd_en = 1'b1; cycle(); rd_en = 1'b0;
        chk("R9 data via falling read", rd_data, 36'h5_0F0F_1234);
        #10; wr_data = 36'h0_0000_0BAD; wr_en = 1'b1; #10; wr_en = 1'b0;
        repeat (3) cycle();
        chk("R9 rising edge ignored", 36'(empty), 36'h1);
        clr = 1'b1; cycle();
        wr_clk_inv = 1'b0; rd_clk_inv = 1'b0;
        repeat (3) cycle();
        clr = 1'b0;

        // R10: reserved codes ignore transfers
        do_clear(3'd6);
        wr_data = 36'h7_7777_7777; wr_en = 1'b1; repeat (3) cycle(); wr_en = 1'b0;
        repeat (3) cycle();
        chk("R10 code 6 empty", 36'(empty), 36'h1);
        chk("R10 code 6 not full", 36'(full), 36'h0);
        rd_en = 1'b1; cycle(); rd_en = 1'b0;
        chk("R10 code 6 rd_data", rd_data, 36'h0);
        do_clear(3'd7);
        wr_en = 1'b1; repeat (2) cycle(); wr_en = 1'b0;
        repeat (3) cycle();
        chk("R10 code 7 empty", 36'(empty), 36'h1);

        // R1: clear of a full FIFO
        do_clear(3'd5);
        af_level = 8'd128; ae_level = 8'd16;
        write_n(128);
        repeat (3) cycle();
        rd_en = 1'b1; cycle(); rd_en = 1'b0;
        do_clear(3'd5);
        chk("R1 full cleared", 36'(full), 36'h0);
        chk("R1 almost_full cleared", 36'(almost_full), 36'h0);
        chk("R1 empty set", 36'(empty), 36'h1);
        chk("R1 almost_empty set", 36'(almost_empty), 36'h1);
        chk("R1 rd_data cleared", rd_data, 36'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule